// File: doc/BRIEF.md
# Multi-Address SMBus Register Target

This block stands in for a group of independent register chips behind a single SMBus target port. A small address table holds up to `N_SLOTS` 7-bit target addresses, ten by default. Each slot owns a private 256-entry byte space, a private 256-entry word space and an 8-bit pointer. The bus side is transaction level. Each request carries a target address, a direction, an operation kind, a command byte and write data. One cycle later the block answers with read data, or with a no-device indication when no active slot claims the address.

The operations are quick, send/receive byte, byte-data and word-data. Each one touches the pointer in its own way. A send-byte loads the pointer. A receive-byte reads through the pointer and advances it. A byte-data access moves the pointer to one past the command. A word-data access leaves the pointer alone. The address table is written one slot at a time. An out-of-range address is refused and reported.

Top module: `smbus_multi_target`

## Requirements
- R1: A table write (`cfg_we`) stores `cfg_addr` into slot `cfg_slot` only when the address is 0 or lies in 0x03..0x77 and the slot index is below `N_SLOTS`. Any other write leaves the table unchanged. From the next cycle until the next table write, `cfg_bad` shows whether the last write was refused (1) or accepted (0).
- R2: A slot holding 0 is inactive, and so is every slot with a higher index. Addresses in those slots are not answered.
- R3: When several active slots hold the same address, the lowest-index slot serves the request.
- R4: A request whose address matches no active slot is answered with `rsp_nodev`=1 and `rsp_rdata`=0, and it changes no byte, word or pointer.
- R5: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise.
- R6: After reset the table is empty, `cfg_bad`=0, `rsp_valid`=0, and every byte, word and pointer of every slot reads as zero.
- R7: A send-byte (`req_kind`=1, `req_read`=0) sets the slot pointer to `req_cmd`.
- R8: A receive-byte (`req_kind`=1, `req_read`=1) returns byte[pointer] in `rsp_rdata[7:0]`, then adds one to the pointer, wrapping 0xFF to 0x00.
- R9: A byte-data access (`req_kind`=2) writes `req_wdata[7:0]` to, or reads, byte[`req_cmd`]. The pointer then becomes `req_cmd`+1, modulo 256.
- R10: A word-data access (`req_kind`=3) writes `req_wdata` to, or reads, word[`req_cmd`] in a space separate from the bytes, and leaves the pointer unchanged.
- R11: A quick command (`req_kind`=0) changes no state. Quick commands and all writes return `rsp_rdata`=0, and byte reads return zero in bits 15:8.
- R12: Slots are independent: an access through one slot never changes the bytes, words or pointer of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Address table write strobe |
| cfg_slot | input | SW | Slot index to write |
| cfg_addr | input | 7 | Address to store (0 ends the list) |
| cfg_bad | output | 1 | Last table write was refused |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 7 | Target address of the request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_kind | input | 2 | 0 quick, 1 byte, 2 byte-data, 3 word-data |
| req_cmd | input | 8 | Command byte |
| req_wdata | input | 16 | Write data (byte kinds use bits 7:0) |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_nodev | output | 1 | No active slot matched |
| rsp_rdata | output | 16 | Read data |

## Verification
The bench builds the block with its defaults: ten slots, so `cfg_slot` is 4 bits wide. Those default widths let the bench write slot indices 10 to 15 and so reach the refused-slot path. They also let a full ten-entry table carry duplicates and a zero terminator in the middle. Commands are drawn from narrow windows near 0x00 and 0xFF. Because of this, pointer wrap, byte-data pointer moves and read-after-write hits all recur within a few thousand transactions.

// File: rtl/smbus_mt_pkg.sv
package smbus_mt_pkg;

    typedef enum logic [1:0] {
        OP_QUICK     = 2'd0,
        OP_BYTE      = 2'd1,
        OP_BYTE_DATA = 2'd2,
        OP_WORD_DATA = 2'd3
    } smb_op_e;

    localparam logic [6:0] ADDR_LO = 7'h03;
    localparam logic [6:0] ADDR_HI = 7'h77;

    typedef struct packed {
        logic       rd;
        smb_op_e    op;
        logic [7:0] cmd;
        logic [15:0] wdata;
    } smb_req_t;

    // zero is legal: it terminates the list
    function automatic logic addr_storable(input logic [6:0] a);
        return (a == 7'd0) || ((a >= ADDR_LO) && (a <= ADDR_HI));
    endfunction

endpackage

// File: rtl/smbus_addr_table.sv
module smbus_addr_table #(
    parameter int N_SLOTS = 10,
    parameter int SW      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_slot,
    input  logic [6:0]    cfg_addr,
    output logic          cfg_bad,
    input  logic [6:0]    look_addr,
    output logic          hit,
    output logic [SW-1:0] hit_slot
);
    import smbus_mt_pkg::*;

    logic [6:0]         tab_q [N_SLOTS];
    logic [N_SLOTS-1:0] active;
    logic [N_SLOTS-1:0] match;
    logic               accept;

    assign accept = addr_storable(cfg_addr) && (int'(cfg_slot) < N_SLOTS);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SLOTS; i++) tab_q[i] <= '0;
            cfg_bad <= 1'b0;
        end else if (cfg_we) begin
            cfg_bad <= !accept;
            if (accept) tab_q[cfg_slot] <= cfg_addr;
        end
    end

    // a slot is live only if it and every lower slot are non-zero
    generate
        for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
            if (g == 0) begin : g_first
                assign active[g] = (tab_q[g] != 7'd0);
            end else begin : g_rest
                assign active[g] = active[g-1] && (tab_q[g] != 7'd0);
            end
            assign match[g] = active[g] && (tab_q[g] == look_addr);
        end
    endgenerate

    always_comb begin
        hit      = |match;
        hit_slot = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (match[i]) hit_slot = SW'(i);
        end
    end

endmodule

// File: rtl/smbus_chip_store.sv
module smbus_chip_store #(
    parameter int N_SLOTS = 10,
    parameter int SW      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [SW-1:0]           slot,
    input  smbus_mt_pkg::smb_req_t  req,
    output logic [15:0]             rdata
);
    import smbus_mt_pkg::*;

    localparam int DEPTH = N_SLOTS * 256;
    localparam int IW    = SW + 8;

    logic [7:0]       bmem [DEPTH];
    logic [15:0]      wmem [DEPTH];
    logic [DEPTH-1:0] bval;
    logic [DEPTH-1:0] wval;
    logic [7:0]       ptr_q [N_SLOTS];

    logic [7:0]    cur_ptr;
    logic [7:0]    boff;
    logic [IW-1:0] bidx;
    logic [IW-1:0] widx;
    logic          bwr;
    logic          wwr;
    logic          ptr_ld;
    logic [7:0]    ptr_nxt;
    logic [15:0]   rd_val;

    always_comb begin
        cur_ptr = ptr_q[slot];
        boff    = (req.op == OP_BYTE) ? cur_ptr : req.cmd;
        bidx    = {slot, boff};
        widx    = {slot, req.cmd};
        bwr     = en && !req.rd && (req.op == OP_BYTE_DATA);
        wwr     = en && !req.rd && (req.op == OP_WORD_DATA);
        ptr_ld  = 1'b0;
        ptr_nxt = cur_ptr;
        rd_val  = '0;
        unique case (req.op)
            OP_QUICK: ;
            OP_BYTE: begin
                ptr_ld = en;
                if (req.rd) begin
                    ptr_nxt = cur_ptr + 8'd1;
                    rd_val  = {8'd0, bval[bidx] ? bmem[bidx] : 8'd0};
                end else begin
                    ptr_nxt = req.cmd;
                end
            end
            OP_BYTE_DATA: begin
                ptr_ld  = en;
                ptr_nxt = req.cmd + 8'd1;
                if (req.rd) rd_val = {8'd0, bval[bidx] ? bmem[bidx] : 8'd0};
            end
            OP_WORD_DATA: begin
                if (req.rd) rd_val = wval[widx] ? wmem[widx] : 16'd0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (bwr) bmem[bidx] <= req.wdata[7:0];
        if (wwr) wmem[widx] <= req.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bval  <= '0;
            wval  <= '0;
            rdata <= '0;
            for (int i = 0; i < N_SLOTS; i++) ptr_q[i] <= '0;
        end else begin
            if (bwr) bval[bidx] <= 1'b1;
            if (wwr) wval[widx] <= 1'b1;
            if (ptr_ld) ptr_q[slot] <= ptr_nxt;
            rdata <= (en && req.rd) ? rd_val : 16'd0;
        end
    end

endmodule

// File: rtl/smbus_multi_target.sv
module smbus_multi_target #(
    parameter int N_SLOTS = 10,
    parameter int SW      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_slot,
    input  logic [6:0]    cfg_addr,
    output logic          cfg_bad,
    input  logic          req_valid,
    input  logic [6:0]    req_addr,
    input  logic          req_read,
    input  logic [1:0]    req_kind,
    input  logic [7:0]    req_cmd,
    input  logic [15:0]   req_wdata,
    output logic          rsp_valid,
    output logic          rsp_nodev,
    output logic [15:0]   rsp_rdata
);
    import smbus_mt_pkg::*;

    logic          hit;
    logic [SW-1:0] hit_slot;
    smb_req_t      req;

    always_comb begin
        req.rd    = req_read;
        req.op    = smb_op_e'(req_kind);
        req.cmd   = req_cmd;
        req.wdata = req_wdata;
    end

    smbus_addr_table #(.N_SLOTS(N_SLOTS), .SW(SW)) u_table (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_slot (cfg_slot),
        .cfg_addr (cfg_addr),
        .cfg_bad  (cfg_bad),
        .look_addr(req_addr),
        .hit      (hit),
        .hit_slot (hit_slot)
    );

    smbus_chip_store #(.N_SLOTS(N_SLOTS), .SW(SW)) u_store (
        .clk  (clk),
        .rst  (rst),
        .en   (req_valid && hit),
        .slot (hit_slot),
        .req  (req),
        .rdata(rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_nodev <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_nodev <= req_valid && !hit;
        end
    end

endmodule

// File: rtl/smbus_multi_target_chk.sv
module smbus_multi_target_chk #(
    parameter int N_SLOTS = 10,
    parameter int SW      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [SW-1:0] cfg_slot,
    input logic [6:0]    cfg_addr,
    input logic          cfg_bad,
    input logic          req_valid,
    input logic          req_read,
    input logic [1:0]    req_kind,
    input logic          rsp_valid,
    input logic          rsp_nodev,
    input logic [15:0]   rsp_rdata
);
    logic cfg_ok;
    assign cfg_ok = (int'(cfg_slot) < N_SLOTS) &&
                    ((cfg_addr == 7'd0) || (cfg_addr >= 7'h03 && cfg_addr <= 7'h77));

    AST_CFG_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_ok) |=> cfg_bad); // R1
    AST_CFG_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_ok) |=> !cfg_bad); // R1
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_bad)); // R1
    AST_NODEV_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_nodev |-> (rsp_valid && rsp_rdata == 16'd0)); // R4
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R5
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R5
    AST_QUIET_DATA: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (!req_read || req_kind == 2'd0)) |=> (rsp_rdata == 16'd0)); // R11
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_kind == 2'd1 || req_kind == 2'd2)) |=> (rsp_rdata[15:8] == 8'd0)); // R11

endmodule

bind smbus_multi_target smbus_multi_target_chk #(.N_SLOTS(N_SLOTS), .SW(SW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_slot (cfg_slot),
    .cfg_addr (cfg_addr),
    .cfg_bad  (cfg_bad),
    .req_valid(req_valid),
    .req_read (req_read),
    .req_kind (req_kind),
    .rsp_valid(rsp_valid),
    .rsp_nodev(rsp_nodev),
    .rsp_rdata(rsp_rdata)
);

// File: tb/tb_smbus_multi_target.sv
module tb_smbus_multi_target;
    localparam int N  = 10;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_slot = '0;
    logic [6:0]    cfg_addr = '0;
    logic          cfg_bad;
    logic          req_valid = 1'b0;
    logic [6:0]    req_addr = '0;
    logic          req_read = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [7:0]    req_cmd = '0;
    logic [15:0]   req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_nodev;
    logic [15:0]   rsp_rdata;

    always #2 clk = ~clk;

    smbus_multi_target #(.N_SLOTS(N)) dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [6:0]  m_tab   [N];
    logic [7:0]  m_ptr   [N];
    logic [7:0]  m_bytes [N][256];
    logic [15:0] m_words [N][256];

    function automatic int m_lookup(input logic [6:0] a);
        for (int i = 0; i < N; i++) begin
            if (m_tab[i] == 7'd0) return -1;
            if (m_tab[i] == a) return i;
        end
        return -1;
    endfunction

    function automatic bit m_storable(input int slot, input logic [6:0] a);
        return (slot < N) && ((a == 7'd0) || (a >= 7'h03 && a <= 7'h77));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int slot, input logic [6:0] a, input string tag);
        bit ok;
        ok = m_storable(slot, a);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = SW'(slot); cfg_addr = a;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ok) m_tab[slot] = a;
        check(tag, {31'd0, cfg_bad}, {31'd0, !ok});
    endtask

    task automatic xact(input logic [6:0] a, input logic rd, input logic [1:0] k,
                        input logic [7:0] c, input logic [15:0] wd, input string tag);
        int s;
        logic [15:0] exp_d;
        logic exp_nd;
        s = m_lookup(a);
        exp_d = 16'd0;
        exp_nd = (s < 0);
        if (s >= 0) begin
            case (k)
                2'd1: if (rd) begin
                          exp_d = {8'd0, m_bytes[s][m_ptr[s]]};
                          m_ptr[s] = m_ptr[s] + 8'd1;
                      end else m_ptr[s] = c;
                2'd2: begin
                          if (rd) exp_d = {8'd0, m_bytes[s][c]};
                          else m_bytes[s][c] = wd[7:0];
                          m_ptr[s] = c + 8'd1;
                      end
                2'd3: if (rd) exp_d = m_words[s][c];
                      else m_words[s][c] = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_read = rd; req_kind = k;
        req_cmd = c; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {14'd0, rsp_valid, rsp_nodev, rsp_rdata}, {14'd0, 1'b1, exp_nd, exp_d});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < N; i++) begin
            m_tab[i] = '0; m_ptr[i] = '0;
            for (int j = 0; j < 256; j++) begin
                m_bytes[i][j] = '0; m_words[i][j] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R6: reset state at the ports
        check("R6 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R6 cfg_bad", {31'd0, cfg_bad}, 32'd0);
        @(negedge clk);
        check("R5 idle", {31'd0, rsp_valid}, 32'd0);
        xact(7'h10, 1, 2'd2, 8'h05, 16'h0, "R6 empty table R4");

        cfg_write(0, 7'h10, "R1 slot0");
        cfg_write(1, 7'h11, "R1 slot1");
        cfg_write(2, 7'h12, "R1 slot2");
        xact(7'h10, 1, 2'd2, 8'h05, 16'h0, "R6 byte zero");
        xact(7'h11, 1, 2'd3, 8'h40, 16'h0, "R6 word zero");
        xact(7'h12, 1, 2'd1, 8'h00, 16'h0, "R6 ptr zero");

        cfg_write(3, 7'h78, "R1 above range");
        xact(7'h78, 1, 2'd0, 8'h00, 16'h0, "R1 refused addr nodev");
        cfg_write(3, 7'h02, "R1 below range");
        cfg_write(12, 7'h20, "R1 slot out of range");
        cfg_write(3, 7'h03, "R1 low bound");
        xact(7'h03, 0, 2'd0, 8'h00, 16'h0, "R1 quick to low bound");

        // R2 termination in the middle
        cfg_write(1, 7'h00, "R2 clear slot1");
        xact(7'h12, 1, 2'd2, 8'h00, 16'h0, "R2 above terminator nodev");
        xact(7'h12, 0, 2'd2, 8'h01, 16'h00EE, "R4 write to nodev");
        cfg_write(1, 7'h11, "R2 restore slot1");
        xact(7'h12, 1, 2'd2, 8'h01, 16'h0, "R4 no state change");

        // R3 duplicate resolution
        cfg_write(3, 7'h10, "R3 duplicate");
        xact(7'h10, 0, 2'd2, 8'h07, 16'h00AB, "R3 write via dup");
        cfg_write(0, 7'h30, "R3 move slot0");
        xact(7'h30, 1, 2'd2, 8'h07, 16'h0, "R3 lowest slot got data");
        xact(7'h10, 1, 2'd2, 8'h07, 16'h0, "R3 higher slot untouched R12");

        // R7 R8 wrap
        xact(7'h30, 0, 2'd2, 8'hFF, 16'h005A, "R9 write FF");
        xact(7'h30, 0, 2'd2, 8'h00, 16'h00C3, "R9 write 00");
        xact(7'h30, 0, 2'd1, 8'hFF, 16'h0, "R7 send byte");
        xact(7'h30, 1, 2'd1, 8'h00, 16'h0, "R8 receive at FF");
        xact(7'h30, 1, 2'd1, 8'h00, 16'h0, "R8 wrap to 00");
        xact(7'h30, 1, 2'd2, 8'hFF, 16'h0, "R9 read FF");
        xact(7'h30, 1, 2'd1, 8'h00, 16'h0, "R9 ptr wrapped to 00");
        // R10 word space separate, pointer untouched
        xact(7'h30, 0, 2'd3, 8'h07, 16'hBEEF, "R10 word write");
        xact(7'h30, 1, 2'd3, 8'h07, 16'h0, "R10 word read");
        xact(7'h30, 1, 2'd1, 8'h00, 16'h0, "R10 ptr unchanged");
        xact(7'h30, 1, 2'd2, 8'h07, 16'h0, "R10 byte space separate");
        // R11 quick
        xact(7'h30, 1, 2'd0, 8'h22, 16'hFFFF, "R11 quick read");
        xact(7'h30, 1, 2'd1, 8'h00, 16'h0, "R11 ptr after quick");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [6:0] pool [8];
            logic [6:0] a;
            logic [1:0] k;
            logic [7:0] c;
            logic rd;
            string tag;
            pool = '{7'h10, 7'h11, 7'h12, 7'h30, 7'h03, 7'h21, 7'h44, 7'h7F};
            if ($urandom_range(0, 49) == 0) begin
                int sl;
                sl = $urandom_range(0, 15);
                a = ($urandom_range(0, 5) == 0) ? 7'd0 : pool[$urandom_range(0, 7)];
                cfg_write(sl, a, "R1 random cfg");
            end else begin
                a  = pool[$urandom_range(0, 7)];
                k  = 2'($urandom_range(0, 3));
                rd = 1'($urandom_range(0, 1));
                c  = $urandom_range(0, 1) ? 8'($urandom_range(0, 7)) : 8'($urandom_range(248, 255));
                case (k)
                    2'd0: tag = "R11 rand quick";
                    2'd1: tag = rd ? "R8 rand receive" : "R7 rand send";
                    2'd2: tag = "R9 rand byte-data R12";
                    default: tag = "R10 rand word-data R12";
                endcase
                xact(a, rd, k, c, 16'($urandom), tag);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule